// File: doc/BRIEF.md
# Flash Main-Area Address and Protection Gate

This block sits in front of a 32 KB flash main area and judges each bus request before it goes to the array. A request carries a byte address, an access size and one flag saying where it comes from: the processor or the debug port. The block decodes the address against the area's fixed physical window. It also decodes the address against an optional mirror of that window at address zero. For a hit it gives the 512-byte block index that the address falls in, and it returns one verdict: allow, or error.

Protection is set by three configuration inputs. `memSwap` turns the mirror at zero off while it is high; a low level, the default, keeps the mirror on. `protectOn` marks memory protection as active. `bootBlocks` gives the number of blocks, counted from block 0, that form the boot section. All blocks above it form the program section. While protection is active, debug-port reads are refused and writes into the boot section are refused. Each refusal sets a sticky violation flag. Misaligned accesses are refused on their own account and do not touch that flag.

The verdict is registered. It appears on the response outputs one clock after the request is presented.

Top module: `flash_gate`

## Requirements
- R1: An address in 0x1000_0000..0x1000_7FFF is a hit, and the block index reported for it is address bits [14:9].
- R2: While `memSwap` is 0, addresses 0x0000_0000..0x0000_7FFF are also a hit, with the same block index rule. While `memSwap` is 1, they are a miss.
- R3: A miss gives `rspHit`=0, `rspAllow`=0, `rspErr`=0 and `rspBlock`=0, and leaves the violation flag unchanged.
- R4: An aligned processor read that hits is always allowed, whatever the protection state, the section and the size (size code 0 = byte, 1 = half-word, 2 = word). `rspAllow` and `rspErr` are never both 1.
- R5: An aligned debug-port read that hits is allowed while `protectOn` is 0. While `protectOn` is 1 it is refused with `rspErr`=1.
- R6: While `protectOn` is 1, an aligned write that hits a block below the effective boot count is refused with `rspErr`=1, and a write that hits a block at or above that count is allowed. While `protectOn` is 0, every aligned write that hits is allowed.
- R7: The effective boot count is `bootBlocks` held to the range 1..63: a value of 0 acts as 1, and any value above 63 acts as 63.
- R8: A hit is refused with `rspErr`=1 and leaves the violation flag unchanged when it is misaligned. A hit is misaligned when its size is 1 and address bit 0 is set, or its size is 2 and address bits [1:0] are not 00, or its size code is 3.
- R9: `violSticky` is set by every refusal that comes from protection (R5, R6), and it stays set until reset.
- R10: A response (`rspValid`=1) comes exactly one cycle after each cycle with `reqValid`=1, and at no other time.
- R11: After reset, all response outputs and `violSticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqAddr | input | 32 | Byte address of the request |
| reqSize | input | 2 | Size code: 0 byte, 1 half-word, 2 word, 3 invalid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDebug | input | 1 | 1 = debug port, 0 = processor |
| memSwap | input | 1 | 1 turns the mirror at address zero off |
| protectOn | input | 1 | Memory protection is active |
| bootBlocks | input | 7 | Number of boot-section blocks, before the clamp |
| rspValid | output | 1 | The response fields below are valid |
| rspHit | output | 1 | The address fell in the main area or its mirror |
| rspAllow | output | 1 | The access may proceed |
| rspErr | output | 1 | The access is refused with an error |
| rspBlock | output | 6 | Block index of the hit, 0 on a miss |
| violSticky | output | 1 | A protection refusal has occurred since reset |

## Verification
The assertions check several rules on every cycle: the one-cycle response timing, that allow and error never come together, that a miss stays quiet, that byte reads from the processor never fail, and that debug reads under protection and invalid sizes are never allowed. They also check that the violation flag only rises with a refused hit and never falls. Other behaviour depends on particular address values and configuration settings, so only the bench scenarios can show it. This covers the exact block indices at both ends of the window, the mirror turning on and off with `memSwap`, and the boot/program boundary on both sides of it. It also covers the clamp of a zero and of an oversized boot count, and that misaligned refusals leave the flag clear.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // Strobes from the control module to the datapath for one request.
  typedef struct packed {
    logic respond;
    logic hit;
    logic allow;
    logic err;
    logic setViol;
  } gateStrobe_t;

endpackage

// File: rtl/flash_gate_ctrl.sv
module flash_gate_ctrl
  import flash_gate_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqDebug,
  input  logic        protectOn,
  input  logic        hit,
  input  logic        aligned,
  input  logic        inBoot,
  output gateStrobe_t strobe
);

  // Order of the checks: the window first, then alignment, then protection.
  always_comb begin
    strobe = '0;
    if (reqValid) begin
      strobe.respond = 1'b1;
      if (hit) begin
        strobe.hit = 1'b1;
        if (!aligned) begin
          strobe.err = 1'b1;
        end else if (reqWrite) begin
          if (protectOn && inBoot) begin
            strobe.err     = 1'b1;
            strobe.setViol = 1'b1;
          end else begin
            strobe.allow = 1'b1;
          end
        end else begin
          if (protectOn && reqDebug) begin
            strobe.err     = 1'b1;
            strobe.setViol = 1'b1;
          end else begin
            strobe.allow = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/flash_gate_dp.sv
module flash_gate_dp
  import flash_gate_pkg::*;
#(
  parameter logic [31:0] AREA_BASE   = 32'h1000_0000,
  parameter int          AREA_BYTES  = 32768,
  parameter int          BLOCK_BYTES = 512,
  localparam int AREA_AW    = $clog2(AREA_BYTES),
  localparam int BLK_OFF_W  = $clog2(BLOCK_BYTES),
  localparam int NUM_BLOCKS = AREA_BYTES / BLOCK_BYTES,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int BOOT_W     = BLK_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              memSwap,
  input  logic [BOOT_W-1:0] bootBlocks,
  input  gateStrobe_t       strobe,
  output logic              hit,
  output logic              aligned,
  output logic              inBoot,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspAllow,
  output logic              rspErr,
  output logic [BLK_W-1:0]  rspBlock,
  output logic              violSticky
);

  localparam int UP_W = 32 - AREA_AW;
  localparam logic [UP_W-1:0]   PHYS_TAG = AREA_BASE[31:AREA_AW];
  localparam logic [BOOT_W-1:0] BOOT_MIN = BOOT_W'(1);
  localparam logic [BOOT_W-1:0] BOOT_MAX = BOOT_W'(NUM_BLOCKS - 1);

  logic [UP_W-1:0]   upper;
  logic              physHit, aliasHit;
  logic [BLK_W-1:0]  blockIdx;
  logic [BOOT_W-1:0] bootEff;
  accSize_e          sizeCode;
  logic              unusedOffset;

  assign upper        = reqAddr[31:AREA_AW];
  assign physHit      = (upper == PHYS_TAG);
  assign aliasHit     = !memSwap && (upper == '0);
  assign hit          = physHit || aliasHit;
  assign blockIdx     = reqAddr[AREA_AW-1:BLK_OFF_W];
  assign sizeCode     = accSize_e'(reqSize);
  assign unusedOffset = ^reqAddr[BLK_OFF_W-1:2];

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = !reqAddr[0];
      SZ_WORD: aligned = (reqAddr[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  // Boundary clamp: the boot and program sections each keep at least one block.
  always_comb begin
    if (bootBlocks < BOOT_MIN)      bootEff = BOOT_MIN;
    else if (bootBlocks > BOOT_MAX) bootEff = BOOT_MAX;
    else                            bootEff = bootBlocks;
  end

  assign inBoot = ({1'b0, blockIdx} < bootEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspAllow   <= 1'b0;
      rspErr     <= 1'b0;
      rspBlock   <= '0;
      violSticky <= 1'b0;
    end else begin
      rspValid   <= strobe.respond;
      rspHit     <= strobe.hit;
      rspAllow   <= strobe.allow;
      rspErr     <= strobe.err;
      rspBlock   <= strobe.hit ? blockIdx : '0;
      violSticky <= violSticky | strobe.setViol;
    end
  end

endmodule

// File: rtl/flash_gate.sv
module flash_gate
  import flash_gate_pkg::*;
#(
  parameter logic [31:0] AREA_BASE   = 32'h1000_0000,
  parameter int          AREA_BYTES  = 32768,
  parameter int          BLOCK_BYTES = 512,
  localparam int NUM_BLOCKS = AREA_BYTES / BLOCK_BYTES,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int BOOT_W     = BLK_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqDebug,
  input  logic              memSwap,
  input  logic              protectOn,
  input  logic [BOOT_W-1:0] bootBlocks,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspAllow,
  output logic              rspErr,
  output logic [BLK_W-1:0]  rspBlock,
  output logic              violSticky
);

  gateStrobe_t strobe;
  logic        hit, aligned, inBoot;

  flash_gate_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqDebug (reqDebug),
    .protectOn(protectOn),
    .hit      (hit),
    .aligned  (aligned),
    .inBoot   (inBoot),
    .strobe   (strobe)
  );

  flash_gate_dp #(
    .AREA_BASE  (AREA_BASE),
    .AREA_BYTES (AREA_BYTES),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .memSwap   (memSwap),
    .bootBlocks(bootBlocks),
    .strobe    (strobe),
    .hit       (hit),
    .aligned   (aligned),
    .inBoot    (inBoot),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspAllow  (rspAllow),
    .rspErr    (rspErr),
    .rspBlock  (rspBlock),
    .violSticky(violSticky)
  );

endmodule

// File: rtl/flash_gate_chk.sv
module flash_gate_chk #(
  parameter int BLK_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqSize,
  input logic             reqWrite,
  input logic             reqDebug,
  input logic             protectOn,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspAllow,
  input logic             rspErr,
  input logic [BLK_W-1:0] rspBlock,
  input logic             violSticky
);

  p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_spurious_resp_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (!rspAllow && !rspErr && rspBlock == '0));

  p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspAllow && rspErr));

  p_cpu_byte_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqDebug && reqSize == 2'd0) |=> !rspErr);

  p_dbg_read_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqDebug && protectOn) |=> !rspAllow);

  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd3) |=> !rspAllow);

  p_viol_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    violSticky |=> violSticky);

  p_viol_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violSticky) |-> (rspValid && rspHit && rspErr));

endmodule

bind flash_gate flash_gate_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqSize   (reqSize),
  .reqWrite  (reqWrite),
  .reqDebug  (reqDebug),
  .protectOn (protectOn),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspAllow  (rspAllow),
  .rspErr    (rspErr),
  .rspBlock  (rspBlock),
  .violSticky(violSticky)
);

// File: tb/tb_flash_gate.sv
`timescale 1ns/1ps
module tb_flash_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic        reqDebug = 1'b0;
  logic        memSwap = 1'b0;
  logic        protectOn = 1'b0;
  logic [6:0]  bootBlocks = 7'd1;
  logic        rspValid, rspHit, rspAllow, rspErr, violSticky;
  logic [5:0]  rspBlock;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit modelViol = 1'b0;

  typedef struct {
    logic       hit;
    logic       allow;
    logic       err;
    logic [5:0] blk;
    logic       viol;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  always #4 clk = ~clk;

  flash_gate dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqDebug(reqDebug),
    .memSwap(memSwap), .protectOn(protectOn), .bootBlocks(bootBlocks),
    .rspValid(rspValid), .rspHit(rspHit), .rspAllow(rspAllow),
    .rspErr(rspErr), .rspBlock(rspBlock), .violSticky(violSticky)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected verdict, written from the requirement list.
  task automatic send(input logic [31:0] a, input logic [1:0] sz,
                      input logic wr, input logic dbg, input string tag);
    exp_t e;
    logic ok, inW, deny;
    int   bootEff;
    @(negedge clk);
    inW = (a >= 32'h1000_0000 && a <= 32'h1000_7FFF) ||
          (!memSwap && a <= 32'h0000_7FFF);
    ok = (sz == 2'd0) || (sz == 2'd1 && a[0] == 1'b0) ||
         (sz == 2'd2 && a[1:0] == 2'b00);
    bootEff = (bootBlocks == 0) ? 1 : (bootBlocks > 63) ? 63 : int'(bootBlocks);
    deny = wr ? (protectOn && (int'(a[14:9]) < bootEff)) : (protectOn && dbg);
    e.hit   = inW;
    e.blk   = inW ? a[14:9] : 6'd0;
    e.err   = inW && (!ok || deny);
    e.allow = inW && ok && !deny;
    if (inW && ok && deny) modelViol = 1'b1;
    e.viol  = modelViol;
    e.tag   = tag;
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqDebug = dbg;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: the response to a request driven at one falling edge is visible at the next.
  always @(negedge clk) begin
    if (rstN && !finished && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "response without request", 32'(rspValid), 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspHit == e.hit && rspAllow == e.allow && rspErr == e.err &&
              rspBlock == e.blk && violSticky == e.viol, e.tag,
              "{hit,allow,err,blk,viol}",
              {20'd0, rspHit, rspAllow, rspErr, rspBlock, violSticky},
              {20'd0, e.hit, e.allow, e.err, e.blk, e.viol});
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check({rspValid, rspHit, rspAllow, rspErr, rspBlock, violSticky} == '0, "R11",
          "outputs in reset", 32'({rspValid, rspHit, rspAllow, rspErr, rspBlock, violSticky}), 32'd0);
    rstN = 1'b1;
    idle(2);
    check({rspValid, rspHit, rspAllow, rspErr, rspBlock, violSticky} == '0, "R11",
          "outputs after reset", 32'({rspValid, rspHit, rspAllow, rspErr, rspBlock, violSticky}), 32'd0);

    // R1 / R4: physical window, both ends and inside
    send(32'h1000_0000, 2'd2, 1'b0, 1'b0, "R1");
    send(32'h1000_7FFC, 2'd2, 1'b0, 1'b0, "R1");
    send(32'h1000_1203, 2'd0, 1'b0, 1'b0, "R4");
    send(32'h1000_4402, 2'd1, 1'b0, 1'b0, "R4");
    // R2: mirror at zero on, then off
    send(32'h0000_0400, 2'd2, 1'b0, 1'b0, "R2");
    send(32'h0000_7FFF, 2'd0, 1'b0, 1'b0, "R2");
    idle(1);
    memSwap = 1'b1;
    send(32'h0000_0400, 2'd2, 1'b0, 1'b0, "R2");
    send(32'h1000_0400, 2'd2, 1'b0, 1'b0, "R2");
    // R3: misses around the window
    send(32'h1000_8000, 2'd2, 1'b0, 1'b0, "R3");
    send(32'h0FFF_FFFC, 2'd2, 1'b1, 1'b1, "R3");
    send(32'h2000_0000, 2'd3, 1'b0, 1'b0, "R3");
    idle(1);
    memSwap = 1'b0;
    // R8: misaligned hits refused, flag untouched
    send(32'h1000_0001, 2'd1, 1'b0, 1'b0, "R8");
    send(32'h1000_0002, 2'd2, 1'b0, 1'b0, "R8");
    send(32'h1000_0000, 2'd3, 1'b0, 1'b0, "R8");
    send(32'h0000_0103, 2'd2, 1'b1, 1'b0, "R8");
    // R5: debug read allowed with protection off; R6 writes allowed with protection off
    send(32'h1000_0010, 2'd2, 1'b0, 1'b1, "R5");
    bootBlocks = 7'd4;
    send(32'h1000_0000, 2'd2, 1'b1, 1'b0, "R6");
    idle(1);
    protectOn = 1'b1;
    // R4: processor reads in the boot section allowed under protection
    send(32'h1000_0000, 2'd2, 1'b0, 1'b0, "R4");
    send(32'h0000_0201, 2'd0, 1'b0, 1'b0, "R4");
    // R6: boundary with four boot blocks
    send(32'h1000_0600, 2'd2, 1'b1, 1'b0, "R6");
    send(32'h1000_0800, 2'd2, 1'b1, 1'b0, "R6");
    send(32'h1000_7FFE, 2'd1, 1'b1, 1'b1, "R6");
    // R5 / R9: debug read refused, flag stays set afterwards
    send(32'h1000_0800, 2'd2, 1'b0, 1'b1, "R5");
    send(32'h1000_0800, 2'd2, 1'b0, 1'b0, "R9");
    // R7: clamp of zero and of an oversized count
    idle(1);
    bootBlocks = 7'd0;
    send(32'h1000_0000, 2'd2, 1'b1, 1'b0, "R7");
    send(32'h1000_0200, 2'd2, 1'b1, 1'b0, "R7");
    idle(1);
    bootBlocks = 7'd100;
    send(32'h1000_7C00, 2'd2, 1'b1, 1'b0, "R7");
    send(32'h1000_7E00, 2'd2, 1'b1, 1'b0, "R7");
    // R10: idle cycles give no response; all expected responses arrive
    idle(6);
    check(expQ.size() == 0, "R10", "responses outstanding", 32'(expQ.size()), 32'd0);
    check(violSticky == 1'b1, "R9", "sticky flag after idle", 32'(violSticky), 32'd1);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule